// File: doc/BRIEF.md
# Condition Flag Generator

This unit produces the four arithmetic condition flags (negative, zero, carry, overflow) and a sticky saturation flag. It works from the outcome of one data-processing operation. The ALU supplies the result word, the sign bits of both operands and its raw carry/borrow output. The shifter supplies its last shifted-out bit. A two-bit class code says which kind of operation produced the result. When the update enable is asserted, the new flags are captured into a five-bit flag register on the next rising clock. When it is low, the register holds its value.

Carry has a different meaning for each class. An addition reports the carry out of the top bit directly. A subtraction reports the inverse of the borrow, so a set carry means no borrow occurred. A logical operation with a shift takes the shifter's bit. A logical operation without a shift keeps the old carry. Overflow changes only for additions and subtractions.

The saturation flag is set only by a saturation event and is cleared only by a direct write of the status field. That write loads all five flags at once and wins over a simultaneous update. The flag register maps onto the top five bits of a status word: N at bit 31, Z at 30, C at 29, V at 28 and Q at 27.

Top module: `cond_flag_unit`

## Requirements
- R1: While rst_n is low, flags_o is 5'b00000.
- R2: On a clock edge with upd_en high and st_wr_en low, flags_o[4] (N) becomes bit DW-1 of result.
- R3: On such an update edge, flags_o[3] (Z) becomes 1 exactly when every bit of result is 0.
- R4: For op_class 2'b00 (addition or compare-negative), flags_o[2] (C) becomes alu_cout, which is the carry out of the top bit.
- R5: For op_class 2'b01 (subtraction or compare), alu_cout is the borrow (1 = borrow), and C becomes its inverse.
- R6: For op_class 2'b10 (logical with shift), C becomes shift_cout, and alu_cout is ignored.
- R7: For op_class 2'b11 (logical without shift), C keeps its previous value.
- R8: For op_class 2'b00, flags_o[1] (V) becomes 1 exactly when both operand signs are equal and the result sign differs from them.
- R9: For op_class 2'b01, V becomes 1 exactly when the operand signs differ and the result sign differs from the first operand's sign.
- R10: For op_class 2'b10 and 2'b11, V keeps its previous value.
- R11: flags_o[0] (Q) is set by an update edge with sat_evt high and is never cleared by an update.
- R12: An edge with st_wr_en high loads flags_o from st_wr_val, with the same bit order, whatever upd_en is. This is the only way Q returns to 0.
- R13: An edge with upd_en and st_wr_en both low leaves every flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| result | input | DW | Result word of the operation |
| op_a_sign | input | 1 | Sign bit of the first operand |
| op_b_sign | input | 1 | Sign bit of the second operand |
| alu_cout | input | 1 | ALU carry (add) or borrow (subtract) |
| shift_cout | input | 1 | Last bit shifted out by the shifter |
| op_class | input | 2 | 00 add, 01 subtract, 10 logical+shift, 11 logical |
| sat_evt | input | 1 | Saturating operation overflowed |
| upd_en | input | 1 | Capture new flags this cycle |
| st_wr_en | input | 1 | Direct write of the flag field |
| st_wr_val | input | 5 | Value for the direct write, {N,Z,C,V,Q} |
| flags_o | output | 5 | Registered flags {N,Z,C,V,Q} (status bits 31..27) |

## Verification
The bench targets several corner cases, and each one exposes a specific mistake. An all-ones plus one addition produces a carry with a zero result; a design that confused carry with overflow would raise V there. A subtraction of equal values must give C=1 and Z=1, and zero minus one must give C=0; a design that passed the borrow through without inverting it gets both of these backwards. The most-negative value minus one and the largest positive value plus one each overflow; an overflow rule that tested the wrong operand sign would miss one of them. Logical operations are driven with a random ALU carry, which catches a design that lets that carry leak into C or that disturbs V. Q is checked across later updates without saturation, so a Q rebuilt on every update would drop. Idle cycles and writes made together with an update show any mistake in hold behaviour or write priority.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

  typedef enum logic [1:0] {
    OPC_ADD   = 2'b00,
    OPC_SUB   = 2'b01,
    OPC_LOGSH = 2'b10,
    OPC_LOGPL = 2'b11
  } opc_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
    logic q;
  } flags_t;

  // signed overflow of a+b, judged from sign bits only
  function automatic logic add_ovf(input logic sa, input logic sb, input logic sr);
    return (sa == sb) && (sr != sa);
  endfunction

  // signed overflow of a-b, judged from sign bits only
  function automatic logic sub_ovf(input logic sa, input logic sb, input logic sr);
    return (sa != sb) && (sr != sa);
  endfunction

  // carry selection per operation class
  function automatic logic pick_carry(input opc_e opc, input logic alu_c,
                                      input logic sh_c, input logic old_c);
    case (opc)
      OPC_ADD:   return alu_c;
      OPC_SUB:   return ~alu_c;
      OPC_LOGSH: return sh_c;
      default:   return old_c;
    endcase
  endfunction

endpackage

// File: rtl/cfg_nzcv_calc.sv
module cfg_nzcv_calc
  import cfg_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] res,
  input  logic          a_sign,
  input  logic          b_sign,
  input  logic          alu_c,
  input  logic          sh_c,
  input  logic [1:0]    opc_raw,
  input  logic          cur_c,
  input  logic          cur_v,
  output logic          n_nxt,
  output logic          z_nxt,
  output logic          c_nxt,
  output logic          v_nxt,
  output logic          add_ovf_ev,
  output logic          sub_ovf_ev
);
  localparam int MSB = DW - 1;

  opc_e opc;
  assign opc = opc_e'(opc_raw);

  assign n_nxt      = res[MSB];
  assign z_nxt      = ~|res;
  assign add_ovf_ev = add_ovf(a_sign, b_sign, res[MSB]);
  assign sub_ovf_ev = sub_ovf(a_sign, b_sign, res[MSB]);
  assign c_nxt      = pick_carry(opc, alu_c, sh_c, cur_c);

  always_comb begin
    case (opc)
      OPC_ADD: v_nxt = add_ovf_ev;
      OPC_SUB: v_nxt = sub_ovf_ev;
      default: v_nxt = cur_v;
    endcase
  end
endmodule

// File: rtl/cfg_q_track.sv
module cfg_q_track (
  input  logic clk,
  input  logic rst_n,
  input  logic upd_en,
  input  logic sat_evt,
  input  logic wr_en,
  input  logic wr_q,
  output logic q_o,
  output logic q_set_ev
);
  logic q_d;

  assign q_set_ev = upd_en & sat_evt & ~wr_en;

  always_comb begin
    if (wr_en)         q_d = wr_q;
    else if (q_set_ev) q_d = 1'b1;
    else               q_d = q_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= q_d;
  end
endmodule

// File: rtl/cond_flag_unit.sv
module cond_flag_unit
  import cfg_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] result,
  input  logic          op_a_sign,
  input  logic          op_b_sign,
  input  logic          alu_cout,
  input  logic          shift_cout,
  input  logic [1:0]    op_class,
  input  logic          sat_evt,
  input  logic          upd_en,
  input  logic          st_wr_en,
  input  logic [4:0]    st_wr_val,
  output logic [4:0]    flags_o
);
  flags_t fl_q;
  logic   n_w, z_w, c_w, v_w;
  logic   add_ovf_w, sub_ovf_w;
  logic   q_w, q_set_w;
  logic   take_upd;
  logic [3:0] nzcv_q, nzcv_d;

  assign take_upd = upd_en & ~st_wr_en;

  cfg_nzcv_calc #(.DW(DW)) u_calc (
    .res        (result),
    .a_sign     (op_a_sign),
    .b_sign     (op_b_sign),
    .alu_c      (alu_cout),
    .sh_c       (shift_cout),
    .opc_raw    (op_class),
    .cur_c      (nzcv_q[1]),
    .cur_v      (nzcv_q[0]),
    .n_nxt      (n_w),
    .z_nxt      (z_w),
    .c_nxt      (c_w),
    .v_nxt      (v_w),
    .add_ovf_ev (add_ovf_w),
    .sub_ovf_ev (sub_ovf_w)
  );

  cfg_q_track u_q (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_en   (upd_en),
    .sat_evt  (sat_evt),
    .wr_en    (st_wr_en),
    .wr_q     (st_wr_val[0]),
    .q_o      (q_w),
    .q_set_ev (q_set_w)
  );

  always_comb begin
    if (st_wr_en)      nzcv_d = st_wr_val[4:1];
    else if (take_upd) nzcv_d = {n_w, z_w, c_w, v_w};
    else               nzcv_d = nzcv_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nzcv_q <= 4'b0000;
    else        nzcv_q <= nzcv_d;
  end

  assign fl_q    = flags_t'({nzcv_q, q_w});
  assign flags_o = fl_q;
endmodule

// File: rtl/cfg_flag_chk.sv
module cfg_flag_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] result,
  input logic [1:0]    op_class,
  input logic          upd_en,
  input logic          st_wr_en,
  input logic [4:0]    st_wr_val,
  input logic          add_ovf_ev,
  input logic          sub_ovf_ev,
  input logic          q_set_ev,
  input logic [4:0]    flags_o
);
  logic upd_ok;
  assign upd_ok = upd_en & ~st_wr_en;

  always_comb begin
    if (!rst_n) assert_rst_R1: assert (flags_o == 5'b00000);
  end

  assert_n_R2: assert property (@(posedge clk) disable iff (!rst_n)
    upd_ok |=> flags_o[4] == $past(result[DW-1]));

  assert_z_R3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_ok |=> flags_o[3] == ($past(result) == '0));

  assert_v_add_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_ok && op_class == 2'b00) |=> flags_o[1] == $past(add_ovf_ev));

  assert_v_sub_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_ok && op_class == 2'b01) |=> flags_o[1] == $past(sub_ovf_ev));

  assert_v_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_ok && op_class[1]) |=> $stable(flags_o[1]));

  assert_c_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_ok && op_class == 2'b11) |=> $stable(flags_o[2]));

  assert_q_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    q_set_ev |=> flags_o[0]);

  assert_q_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o[0] && !st_wr_en) |=> flags_o[0]);

  assert_wr_R12: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr_en |=> flags_o == $past(st_wr_val));

  assert_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_en && !st_wr_en) |=> $stable(flags_o));
endmodule

bind cond_flag_unit cfg_flag_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .result     (result),
  .op_class   (op_class),
  .upd_en     (upd_en),
  .st_wr_en   (st_wr_en),
  .st_wr_val  (st_wr_val),
  .add_ovf_ev (add_ovf_w),
  .sub_ovf_ev (sub_ovf_w),
  .q_set_ev   (q_set_w),
  .flags_o    (flags_o)
);

// File: tb/sim_cond_flag_unit.sv
module sim_cond_flag_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] result = '0;
  logic        op_a_sign = 1'b0, op_b_sign = 1'b0;
  logic        alu_cout = 1'b0, shift_cout = 1'b0;
  logic [1:0]  op_class = 2'b00;
  logic        sat_evt = 1'b0, upd_en = 1'b0, st_wr_en = 1'b0;
  logic [4:0]  st_wr_val = '0;
  logic [4:0]  flags_o;

  int nchk = 0;
  int nbad = 0;
  logic en = 0, ez = 0, ec = 0, ev = 0, eq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cond_flag_unit #(.DW(32)) u0 (
    .clk(clk), .rst_n(rst_n), .result(result),
    .op_a_sign(op_a_sign), .op_b_sign(op_b_sign),
    .alu_cout(alu_cout), .shift_cout(shift_cout), .op_class(op_class),
    .sat_evt(sat_evt), .upd_en(upd_en), .st_wr_en(st_wr_en),
    .st_wr_val(st_wr_val), .flags_o(flags_o)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got %b expected %b (flags=%b)", tag, act, exp, flags_o);
    end
  endtask

  task automatic chk_all(input string tn, input string tz, input string tc,
                         input string tv, input string tq);
    chk(tn, flags_o[4], en);
    chk(tz, flags_o[3], ez);
    chk(tc, flags_o[2], ec);
    chk(tv, flags_o[1], ev);
    chk(tq, flags_o[0], eq);
  endtask

  // signed-range overflow, restated with 33-bit arithmetic
  function automatic logic ovf33(input logic [31:0] x, input logic [31:0] y, input logic sub);
    logic signed [32:0] s;
    s = sub ? ($signed({x[31], x}) - $signed({y[31], y}))
            : ($signed({x[31], x}) + $signed({y[31], y}));
    return s[32] != s[31];
  endfunction

  task automatic op(input logic [1:0] c, input logic [31:0] x, input logic [31:0] y,
                    input logic s, input logic u, input logic sc);
    logic [32:0] wide;
    logic [31:0] r;
    logic ac;
    string tc, tv;
    case (c)
      2'b00: begin wide = {1'b0, x} + {1'b0, y}; r = wide[31:0]; ac = wide[32]; end
      2'b01: begin r = x - y; ac = (x < y); end
      default: begin r = x ^ y; ac = 1'($urandom); end
    endcase
    tc = (c == 2'b00) ? "R4" : (c == 2'b01) ? "R5" : (c == 2'b10) ? "R6" : "R7";
    tv = (c == 2'b00) ? "R8" : (c == 2'b01) ? "R9" : "R10";
    if (u) begin
      en = r[31];
      ez = (r == 32'd0);
      if (c == 2'b00) ec = ac;
      else if (c == 2'b01) ec = !(x < y);
      else if (c == 2'b10) ec = sc;
      if (c[1] == 1'b0) ev = ovf33(x, y, c[0]);
      if (s) eq = 1'b1;
    end
    @(negedge clk);
    result = r; op_a_sign = x[31]; op_b_sign = y[31];
    alu_cout = ac; shift_cout = sc; op_class = c;
    sat_evt = s; upd_en = u; st_wr_en = 1'b0;
    @(posedge clk); #1;
    if (u) chk_all("R2", "R3", tc, tv, "R11");
    else   chk_all("R13", "R13", "R13", "R13", "R13");
  endtask

  task automatic stwr(input logic [4:0] v, input logic u);
    @(negedge clk);
    st_wr_en = 1'b1; st_wr_val = v; upd_en = u; sat_evt = 1'b1;
    result = 32'hFFFF_0000;
    {en, ez, ec, ev, eq} = v;
    @(posedge clk); #1;
    chk_all("R12", "R12", "R12", "R12", "R12");
    @(negedge clk);
    st_wr_en = 1'b0; upd_en = 1'b0; sat_evt = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #(CLK_PERIOD * 2 + 1);
    chk_all("R1", "R1", "R1", "R1", "R1");
    @(negedge clk); rst_n = 1'b1;

    op(2'b00, 32'hFFFF_FFFF, 32'h1, 0, 1, 0);           // carry, zero, no V
    op(2'b00, 32'h7FFF_FFFF, 32'h1, 0, 1, 0);           // positive overflow
    op(2'b01, 32'h5, 32'h5, 0, 1, 0);                   // equal: C=1 Z=1
    op(2'b01, 32'h0, 32'h1, 0, 1, 0);                   // borrow: C=0 N=1
    op(2'b01, 32'h8000_0000, 32'h1, 0, 1, 0);           // negative overflow
    op(2'b10, 32'hF0F0_0000, 32'h0F0F_0000, 0, 1, 1);   // shift carry in
    op(2'b11, 32'h1234_5678, 32'h1234_5678, 0, 1, 0);   // C, V kept
    op(2'b00, 32'h1, 32'h2, 1, 1, 0);                   // saturation sets Q
    op(2'b01, 32'h9, 32'h3, 0, 1, 0);                   // Q stays set
    op(2'b00, 32'h8000_0000, 32'h8000_0000, 1, 0, 1);   // idle: nothing moves
    stwr(5'b10100, 1'b1);                               // write beats update, clears Q
    stwr(5'b01011, 1'b0);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] x, y;
      x = $urandom; y = $urandom;
      if (i % 7 == 0) y = x;
      op(2'($urandom), x, y, ($urandom % 9) == 0, ($urandom % 5) != 0, 1'($urandom));
      if (i % 97 == 96) stwr(5'($urandom), 1'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule